// File: doc/BRIEF.md
# Completion Expectation Table

This block sits on the request side of a PCI Express transaction layer. Every time an outgoing read or write request is issued, it works out the byte count and the 7-bit lower address that a correct completion for that request has to carry. It then records both values, together with a valid flag, in a small table indexed by the request tag. On the completion side, a checker presents the tag of an arriving completion on a lookup port. The stored expectations come back combinationally and can be compared against the completion header.

The byte count and the two low lower-address bits depend only on the byte-enable byte and the DW length. Bits 3:0 of the byte-enable byte are the first-DW enables and bits 7:4 are the last-DW enables. Byte count is formed from the count of zero bits below the lowest set first enable and the count of zero bits above the highest set last enable. Requests with no last enables, and requests with no enables at all, follow their own rules. The upper lower-address bits come from the final address byte of the request header. For a 4-DW header that byte is header byte 15; for a 3-DW header it is header byte 11. A write that lands on a tag whose entry is still valid raises a one-cycle warning pulse.

Top module: `cpl_expect_table`

## Requirements
- R1: After reset every entry reads back as invalid (lk_vld=0) and dup_warn is 0.
- R2: When all eight byte-enable bits are 0, the stored byte count is 1 and lower-address bits 1:0 are 0.
- R3: With last enables (bits 7:4) all 0 and first enables nonzero, the byte count is 1 if exactly one first-enable bit is set, and 2 for the first-enable patterns 4'b0011, 4'b0110 and 4'b1100.
- R4: With last enables all 0, the byte count is 4 when first-enable bits 0 and 3 are both set, and 3 for every other nonzero pattern not covered by R3.
- R5: Lower-address bits 1:0 hold the number of zero bits below the lowest set bit of the first enables (bits 3:0), taken modulo 4.
- R6: With last enables nonzero, the byte count is 4×DW minus the first-enable trailing-zero count (0..4). When the length is not 1, it further subtracts the number of zero bits above the highest set last-enable bit (counted down from bit 7). A length field of 0 means 1024 DW, and the 12-bit result wraps, so 4096 reads as 0.
- R7: Lower-address bits 6:2 come from req_adr_long when req_fmt is 1 or 3, and from req_adr_short for format 0 or 2.
- R8: A cycle with req_vld=1 writes the entry at req_tag and sets its valid flag. The lookup port shows the new contents from the next cycle on. Other entries keep their contents.
- R9: dup_warn is 1 for exactly the cycle after a write whose target entry was already valid. It is 0 after a write to an invalid entry.
- R10: While req_vld is 0, the table contents and valid flags do not change, whatever the other request inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe; writes one entry |
| req_tag | input | TAG_W | Entry index of the request |
| req_be | input | 8 | Byte enables: 3:0 first DW, 7:4 last DW |
| req_len | input | 10 | DW length, 0 means 1024 |
| req_fmt | input | 2 | Header format; 1 and 3 denote a 4-DW header |
| req_adr_short | input | 5 | Address bits 6:2 from header byte 11 |
| req_adr_long | input | 5 | Address bits 6:2 from header byte 15 |
| lk_tag | input | TAG_W | Lookup index |
| lk_vld | output | 1 | Valid flag of the looked-up entry |
| lk_bc | output | 12 | Expected byte count of the looked-up entry |
| lk_la | output | 7 | Expected lower address of the looked-up entry |
| dup_warn | output | 1 | Pulse: previous write hit a valid entry |

## Verification
The hardest cases to reach from the ports are the subtraction corners of the multi-DW rule. These include a first-enable nibble of zero (trailing count 4) in a multi-DW request, a length of exactly 1 with nonzero last enables (where the leading count must not be subtracted), and a length field of 0 whose 4096-byte total must wrap. Each of these gets its own directed request written to a distinct tag and read back through the lookup port. A neighbouring tag is re-read after an overwrite and after idle cycles with noisy inputs. This shows that writes stay confined to their target entry.

// File: rtl/cpl_expect_pkg.sv
package cpl_expect_pkg;
  localparam int BE_W  = 8;
  localparam int LEN_W = 10;
  localparam int BC_W  = LEN_W + 2;
  localparam int LA_W  = 7;
  localparam int AHI_W = LA_W - 2;

  typedef struct packed {
    logic [BC_W-1:0] bc;
    logic [LA_W-1:0] la;
  } expect_t;
endpackage

// File: rtl/ebc_zcount.sv
// Counts zero bits from one end of a vector up to the first set bit.
module ebc_zcount #(
  parameter int W        = 4,
  parameter bit FROM_MSB = 1'b0,
  localparam int CW      = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] zeros
);
  logic [W-1:0] ordered;

  generate
    if (FROM_MSB) begin : g_rev
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign ordered[i] = vec[W-1-i];
      end
    end else begin : g_fwd
      assign ordered = vec;
    end
  endgenerate

  always_comb begin
    logic hit;
    hit   = 1'b0;
    zeros = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (!hit && ordered[i]) begin
        zeros = CW'(i);
        hit   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ebc_calc.sv
module ebc_calc
  import cpl_expect_pkg::*;
(
  input  logic [BE_W-1:0]  be,
  input  logic [LEN_W-1:0] len,
  input  logic [1:0]       fmt,
  input  logic [AHI_W-1:0] adr_short,
  input  logic [AHI_W-1:0] adr_long,
  output expect_t          result
);
  localparam int HALF = BE_W / 2;
  localparam int ZW   = $clog2(HALF + 1);
  localparam int SW   = LEN_W + 3;

  logic [HALF-1:0] first_be, last_be;
  logic [ZW-1:0]   first_tz, last_lz;
  logic [LEN_W:0]  dwords;
  logic [SW-1:0]   total;
  logic [AHI_W-1:0] adr_hi;

  assign first_be = be[HALF-1:0];
  assign last_be  = be[BE_W-1:HALF];

  ebc_zcount #(.W(HALF), .FROM_MSB(1'b0)) u_first (.vec(first_be), .zeros(first_tz));
  ebc_zcount #(.W(HALF), .FROM_MSB(1'b1)) u_last  (.vec(last_be),  .zeros(last_lz));

  assign adr_hi = (fmt == 2'd1 || fmt == 2'd3) ? adr_long : adr_short;
  assign dwords = (len == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, len};

  always_comb begin
    total = {dwords, 2'b00} - SW'(first_tz);
    if (len != LEN_W'(1)) total = total - SW'(last_lz);
  end

  always_comb begin
    result.la = {adr_hi, first_tz[1:0]};
    if (be == '0) begin
      result.bc = BC_W'(1);
      result.la = {adr_hi, 2'b00};
    end else if (last_be == '0) begin
      if ($countones(first_be) == 1)                             result.bc = BC_W'(1);
      else if (first_be inside {4'b0011, 4'b0110, 4'b1100})      result.bc = BC_W'(2);
      else if (first_be[0] && first_be[HALF-1])                  result.bc = BC_W'(4);
      else                                                       result.bc = BC_W'(3);
    end else begin
      result.bc = total[BC_W-1:0];
    end
  end

  always_comb begin
    if (!$isunknown(be) && first_be != '0) begin
      // R5
      la_low_bit_chk: assert (first_be[result.la[1:0]] == 1'b1);
    end
    if (!$isunknown(be) && last_be == '0) begin
      // R3
      single_dw_range_chk: assert (result.bc >= BC_W'(1) && result.bc <= BC_W'(4));
    end
  end
endmodule

// File: rtl/ebc_store.sv
module ebc_store
  import cpl_expect_pkg::*;
#(
  parameter int TAG_W  = 5,
  localparam int DEPTH = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  expect_t          wr_data,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_vld,
  output expect_t          rd_data,
  output logic             dup_warn
);
  logic [DEPTH-1:0] vld_q;
  expect_t          data_q [DEPTH];
  logic             dup_q, dup_d;

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic    hit;
      logic    vld_d;
      expect_t data_d;

      assign hit = wr_en && (wr_tag == TAG_W'(e));

      always_comb begin
        vld_d  = vld_q[e];
        data_d = data_q[e];
        if (hit) begin
          vld_d  = 1'b1;
          data_d = wr_data;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[e]  <= 1'b0;
          data_q[e] <= '0;
        end else if (hit) begin
          vld_q[e]  <= vld_d;
          data_q[e] <= data_d;
        end
      end
    end
  endgenerate

  assign dup_d = wr_en && vld_q[wr_tag];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dup_q <= 1'b0;
    else        dup_q <= dup_d;
  end

  assign rd_vld   = vld_q[rd_tag];
  assign rd_data  = data_q[rd_tag];
  assign dup_warn = dup_q;

  // R8
  fill_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_tag)]);
  // R8
  fill_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> data_q[$past(wr_tag)] == $past(wr_data));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(vld_q));
  // R9
  warn_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dup_warn |-> $past(wr_en));
endmodule

// File: rtl/cpl_expect_table.sv
module cpl_expect_table
  import cpl_expect_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [7:0]       req_be,
  input  logic [9:0]       req_len,
  input  logic [1:0]       req_fmt,
  input  logic [4:0]       req_adr_short,
  input  logic [4:0]       req_adr_long,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_vld,
  output logic [11:0]      lk_bc,
  output logic [6:0]       lk_la,
  output logic             dup_warn
);
  expect_t calc_res, rd_res;

  ebc_calc u_calc (
    .be        (req_be),
    .len       (req_len),
    .fmt       (req_fmt),
    .adr_short (req_adr_short),
    .adr_long  (req_adr_long),
    .result    (calc_res)
  );

  ebc_store #(.TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (req_vld),
    .wr_tag   (req_tag),
    .wr_data  (calc_res),
    .rd_tag   (lk_tag),
    .rd_vld   (lk_vld),
    .rd_data  (rd_res),
    .dup_warn (dup_warn)
  );

  assign lk_bc = rd_res.bc;
  assign lk_la = rd_res.la;
endmodule

// File: tb/cpl_expect_table_tb_top.sv
module cpl_expect_table_tb_top;
  localparam int TAG_W = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_vld;
  logic [TAG_W-1:0] req_tag;
  logic [7:0]       req_be;
  logic [9:0]       req_len;
  logic [1:0]       req_fmt;
  logic [4:0]       req_adr_short, req_adr_long;
  logic [TAG_W-1:0] lk_tag;
  logic             lk_vld, dup_warn;
  logic [11:0]      lk_bc;
  logic [6:0]       lk_la;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cpl_expect_table #(.TAG_W(TAG_W)) dut_i (.*);

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_req(input int tag, input int be, input int len, input int fmt,
                           input int a_s, input int a_l, output bit warn);
    @(negedge clk);
    req_vld = 1'b1; req_tag = TAG_W'(tag); req_be = 8'(be); req_len = 10'(len);
    req_fmt = 2'(fmt); req_adr_short = 5'(a_s); req_adr_long = 5'(a_l);
    @(negedge clk);
    req_vld = 1'b0;
    warn = dup_warn;
  endtask

  task automatic look(input string req, input int tag, input int vld, input int bc, input int la);
    lk_tag = TAG_W'(tag);
    #1;
    check({req, " valid"}, int'(lk_vld), vld);
    if (vld != 0) begin
      check({req, " bc"}, int'(lk_bc), bc);
      check({req, " la"}, int'(lk_la), la);
    end
  endtask

  task automatic t_reset();
    look("R1 tag0", 0, 0, 0, 0);
    look("R1 tag31", 31, 0, 0, 0);
    check("R1 dup_warn", int'(dup_warn), 0);
  endtask

  task automatic t_zero_be();
    bit w;
    write_req(1, 8'h00, 1, 0, 5'h1F, 5'h00, w);
    look("R2 zero be", 1, 1, 1, 7'h7C);
  endtask

  task automatic t_single_small();
    bit w;
    write_req(2, 8'h04, 1, 0, 0, 0, w);  look("R3 one-hot 0100", 2, 1, 1, 2);
    write_req(3, 8'h06, 1, 0, 0, 0, w);  look("R3 0110", 3, 1, 2, 1);
    write_req(4, 8'h0C, 1, 0, 0, 0, w);  look("R3 1100", 4, 1, 2, 2);
    write_req(5, 8'h03, 1, 0, 0, 0, w);  look("R3 0011", 5, 1, 2, 0);
  endtask

  task automatic t_single_wide();
    bit w;
    write_req(6,  8'h09, 1, 0, 0, 0, w); look("R4 1001", 6, 1, 4, 0);
    write_req(7,  8'h0F, 1, 0, 0, 0, w); look("R4 1111", 7, 1, 4, 0);
    write_req(8,  8'h05, 1, 0, 0, 0, w); look("R4 0101", 8, 1, 3, 0);
    write_req(9,  8'h0E, 1, 0, 0, 0, w); look("R4 1110 R5", 9, 1, 3, 1);
    write_req(10, 8'h0A, 1, 0, 0, 0, w); look("R4 1010 R5", 10, 1, 3, 1);
  endtask

  task automatic t_multi();
    bit w;
    write_req(11, 8'hFF, 4, 0, 0, 0, w); look("R6 full 4dw", 11, 1, 16, 0);
    write_req(12, 8'h3E, 3, 0, 0, 0, w); look("R6 3dw trim", 12, 1, 9, 1);
    write_req(13, 8'h18, 2, 0, 0, 0, w); look("R6 2dw edges R5", 13, 1, 2, 3);
    write_req(14, 8'hF0, 2, 0, 0, 0, w); look("R6 first zero", 14, 1, 4, 0);
    write_req(15, 8'h1C, 1, 0, 0, 0, w); look("R6 len1 no lz", 15, 1, 2, 2);
    write_req(16, 8'hFF, 0, 0, 0, 0, w); look("R6 len0 wrap", 16, 1, 0, 0);
    write_req(17, 8'h8E, 0, 0, 0, 0, w); look("R6 len0 4095", 17, 1, 4095, 1);
  endtask

  task automatic t_format();
    bit w;
    write_req(18, 8'h01, 1, 1, 5'h00, 5'h11, w); look("R7 fmt1 long", 18, 1, 1, 7'h44);
    write_req(19, 8'h01, 1, 3, 5'h1F, 5'h0A, w); look("R7 fmt3 long", 19, 1, 1, 7'h28);
    write_req(20, 8'h01, 1, 2, 5'h15, 5'h1F, w); look("R7 fmt2 short", 20, 1, 1, 7'h54);
  endtask

  task automatic t_overwrite();
    bit w;
    write_req(2, 8'h0F, 1, 0, 0, 0, w);
    check("R9 warn on valid entry", int'(w), 1);
    look("R8 overwrite data", 2, 1, 4, 0);
    look("R8 neighbour kept", 3, 1, 2, 1);
    @(negedge clk);
    check("R9 single pulse", int'(dup_warn), 0);
    write_req(21, 8'h01, 1, 0, 0, 0, w);
    check("R9 no warn on fresh entry", int'(w), 0);
    look("R8 fresh entry", 21, 1, 1, 0);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      req_tag = TAG_W'(22 + (i % 2)); req_be = 8'hA5; req_len = 10'd7;
      req_adr_short = 5'h1F; req_adr_long = 5'h1F;
      req_tag = (i == 3) ? TAG_W'(2) : req_tag;
    end
    @(negedge clk);
    look("R10 idle tag22", 22, 0, 0, 0);
    look("R10 idle tag23", 23, 0, 0, 0);
    look("R10 idle tag2 kept", 2, 1, 4, 0);
    check("R10 no warn", int'(dup_warn), 0);
  endtask

  initial begin
    rst_n = 1'b0; req_vld = 1'b0; req_tag = '0; req_be = '0; req_len = '0;
    req_fmt = '0; req_adr_short = '0; req_adr_long = '0; lk_tag = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_be();
    t_single_small();
    t_single_wide();
    t_multi();
    t_format();
    t_overwrite();
    t_idle();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule